// File: doc/BRIEF.md
# Double-Error Candidate Codeword Enumerator

This block receives one 39-bit word guarded by a (39,32) single-error-correcting, double-error-detecting code whose parity-check columns all have odd weight. It classifies the word from its 7-bit syndrome. A zero syndrome passes the message through. An odd syndrome that equals a column is corrected as a single-bit error. An odd syndrome that matches no column is reported as uncorrectable.

When the syndrome is even and nonzero, the word holds a double-bit error that cannot be corrected. The block then sweeps all 39 bit positions, one per clock. For each position it flips that bit and asks whether the resulting syndrome equals the column of a higher position. Each such pair names one valid codeword at Hamming distance two from the received word. The 32-bit message of each candidate is placed in a parallel output list, with a count. A later recovery stage uses that list to filter and rank the candidates. The stored original message is always one of them.

Words are offered with `in_valid` and accepted while `busy` is low. Results are announced by a one-cycle `done` pulse and stay on the outputs until the next word is accepted.

Top module: `hsec_due_enum`

## Requirements
- R1: Codeword bits [31:0] carry the message and bits [38:32] the check bits. The column for message bit p is the p-th smallest 7-bit value with exactly three ones (ascending, p from 0). The column for check bit 32+k is the value with only bit k set. A word whose syndrome is zero completes with status 0 (clean), `msg_out` equal to bits [31:0] and a count of 0.
- R2: A word with exactly one flipped bit at any of the 39 positions completes with status 1 (single). `msg_out` equals the original message, including when the flipped bit is a check bit. The count is 0.
- R3: A word whose syndrome is even and nonzero completes with status 2 (double) and `msg_out` equal to the raw bits [31:0]. The count equals the number of valid codewords at distance two. Slot k of `cand_list` (bits [32k+31:32k]) holds the message of the k-th such codeword, ordered by the lower of its two differing positions, ascending. Each codeword is listed once.
- R4: For a stored codeword hit by exactly two bit flips, the original message appears among the first `cand_cnt` slots.
- R5: A word whose syndrome has odd weight but equals no column completes with status 3 (multi), `msg_out` equal to the raw bits [31:0] and a count of 0.
- R6: `done` is high for exactly one cycle per accepted word. Counting the accepting clock edge as edge 0, `done` is high after edge 1 for status 0, 1 or 3, and after edge 40 for status 2.
- R7: `busy` is high from the accepting edge until `done`. A word presented on `in_valid` while `busy` is high is ignored: it produces no result and leaves the current result unchanged.
- R8: `status`, `msg_out`, `cand_cnt` and `cand_list` hold their values while no word is accepted. `cand_cnt` never exceeds 16. Slots at or above `cand_cnt` read as zero.
- R9: After reset `busy`, `done`, `status`, `cand_cnt`, `msg_out` and `cand_list` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offers `in_word`; taken when `busy` is low |
| in_word | input | 39 | Received codeword: message [31:0], check bits [38:32] |
| busy | output | 1 | A word is being evaluated or swept |
| done | output | 1 | One-cycle pulse: the result outputs are valid |
| status | output | 2 | 0 clean, 1 single corrected, 2 double (candidates listed), 3 multi uncorrectable |
| msg_out | output | 32 | Corrected or passed-through message |
| cand_cnt | output | 5 | Number of listed candidates |
| cand_list | output | 512 | 16 slots of 32-bit candidate messages, slot k at [32k+31:32k] |

## Verification
Clean codewords with all-zero, all-one and mixed messages confirm that the zero-syndrome path neither flips bits nor starts a sweep. A single flip at each of the 39 positions separates message-bit correction from check-bit errors, which must leave the message untouched. Double flips cover data-data, check-check and data-check pairs, plus pseudo-random pairs. Their syndromes have weight two, four and six, so the candidate counts and orders differ, and each list is compared slot by slot with a brute-force search over all position pairs. A three-bit flip chosen for an odd syndrome that matches no column tells the multi status apart from miscorrection, and a word offered during a sweep checks that the running job is not disturbed.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
  localparam int MSG_W = 32;
  localparam int CHK_W = 7;
  localparam int CW_W  = MSG_W + CHK_W;
  localparam int POS_W = $clog2(CW_W);

  typedef logic [CHK_W-1:0] syn_t;
  typedef logic [CW_W-1:0]  cw_t;
  typedef syn_t [CW_W-1:0]  hcol_t;
  typedef cw_t  [CHK_W-1:0] hrow_t;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_SINGLE = 2'd1,
    ST_DOUBLE = 2'd2,
    ST_MULTI  = 2'd3
  } status_e;

  function automatic int ones_in(input int v);
    int n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += (v >> b) & 1;
    return n;
  endfunction

  // Message columns: weight-3 values in ascending order; check columns: unit vectors.
  function automatic hcol_t build_cols();
    hcol_t t;
    int    n;
    t = '0;
    n = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      if (ones_in(v) == 3 && n < MSG_W) begin
        t[n] = syn_t'(v);
        n++;
      end
    end
    for (int k = 0; k < CHK_W; k++) t[MSG_W + k] = syn_t'(1 << k);
    return t;
  endfunction

  localparam hcol_t HCOL = build_cols();

  // Row masks: which codeword positions feed each syndrome bit.
  function automatic hrow_t build_rows();
    hrow_t r;
    r = '0;
    for (int b = 0; b < CHK_W; b++)
      for (int p = 0; p < CW_W; p++)
        r[b][p] = HCOL[p][b];
    return r;
  endfunction

  localparam hrow_t HROW = build_rows();
endpackage

// File: rtl/hsec_syndrome.sv
module hsec_syndrome
  import hsec_pkg::*;
(
  input  cw_t  word,
  output syn_t syn
);
  for (genvar b = 0; b < CHK_W; b++) begin : g_row
    assign syn[b] = ^(word & HROW[b]);
  end
endmodule

// File: rtl/hsec_col_match.sv
module hsec_col_match
  import hsec_pkg::*;
(
  input  syn_t             syn,
  output logic             hit,
  output logic [POS_W-1:0] pos
);
  logic [CW_W-1:0] eq;

  for (genvar p = 0; p < CW_W; p++) begin : g_col
    assign eq[p] = (syn == HCOL[p]);
  end

  always_comb begin
    hit = |eq;
    pos = '0;
    for (int p = 0; p < CW_W; p++) begin
      if (eq[p]) pos = POS_W'(p);
    end
  end
endmodule

// File: rtl/hsec_cand_store.sv
module hsec_cand_store
  import hsec_pkg::*;
#(
  parameter int MAX_CAND = 16,
  localparam int SLOT_W  = $clog2(MAX_CAND)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      we,
  input  logic [SLOT_W-1:0]         slot,
  input  logic [MSG_W-1:0]          wdata,
  output logic [MAX_CAND*MSG_W-1:0] flat
);
  for (genvar k = 0; k < MAX_CAND; k++) begin : g_slot
    logic [MSG_W-1:0] ent;
    always_ff @(posedge clk) begin
      if (rst || clr) ent <= '0;
      else if (we && slot == SLOT_W'(k)) ent <= wdata;
    end
    assign flat[k*MSG_W +: MSG_W] = ent;
  end
endmodule

// File: rtl/hsec_due_enum.sv
module hsec_due_enum
  import hsec_pkg::*;
#(
  parameter int MAX_CAND = 16,
  localparam int CNT_W   = $clog2(MAX_CAND + 1),
  localparam int SLOT_W  = $clog2(MAX_CAND)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [CW_W-1:0]           in_word,
  output logic                      busy,
  output logic                      done,
  output logic [1:0]                status,
  output logic [MSG_W-1:0]          msg_out,
  output logic [CNT_W-1:0]          cand_cnt,
  output logic [MAX_CAND*MSG_W-1:0] cand_list
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_SWEEP} fsm_e;

  fsm_e             state;
  status_e          st_q;
  logic [MSG_W-1:0] msg_q;
  syn_t             syn_q;
  logic [POS_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  syn_t             in_syn;
  syn_t             trial_syn;
  logic             own_hit, trial_hit;
  logic [POS_W-1:0] own_pos, trial_pos;
  logic             syn_zero, syn_odd;
  logic             accept, take, last_pos;
  logic [MSG_W-1:0] cand_msg;

  hsec_syndrome u_syn (
    .word (in_word),
    .syn  (in_syn)
  );

  // Match of the latched syndrome itself: single-error position.
  hsec_col_match u_own (
    .syn (syn_q),
    .hit (own_hit),
    .pos (own_pos)
  );

  // Match after trial-flipping position idx_q: partner position of a pair.
  assign trial_syn = syn_q ^ HCOL[idx_q];

  hsec_col_match u_trial (
    .syn (trial_syn),
    .hit (trial_hit),
    .pos (trial_pos)
  );

  assign syn_zero = (syn_q == '0);
  assign syn_odd  = ^syn_q;
  assign accept   = (state == S_IDLE) && in_valid;
  assign last_pos = (idx_q == POS_W'(CW_W - 1));
  assign take     = (state == S_SWEEP) && trial_hit && (trial_pos > idx_q)
                    && (cnt_q < CNT_W'(MAX_CAND));
  assign cand_msg = msg_q ^ (MSG_W'(1) << idx_q) ^ (MSG_W'(1) << trial_pos);

  hsec_cand_store #(.MAX_CAND(MAX_CAND)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .we    (take),
    .slot  (cnt_q[SLOT_W-1:0]),
    .wdata (cand_msg),
    .flat  (cand_list)
  );

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      state   <= S_IDLE;
      st_q    <= ST_CLEAN;
      msg_q   <= '0;
      syn_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      msg_out <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            msg_q <= in_word[MSG_W-1:0];
            syn_q <= in_syn;
            idx_q <= '0;
            cnt_q <= '0;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (syn_zero) begin
            st_q    <= ST_CLEAN;
            msg_out <= msg_q;
            done    <= 1'b1;
            state   <= S_IDLE;
          end else if (syn_odd) begin
            if (own_hit) begin
              st_q    <= ST_SINGLE;
              msg_out <= msg_q ^ (MSG_W'(1) << own_pos);
            end else begin
              st_q    <= ST_MULTI;
              msg_out <= msg_q;
            end
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            msg_out <= msg_q;
            state   <= S_SWEEP;
          end
        end
        S_SWEEP: begin
          if (take) cnt_q <= cnt_q + 1'b1;
          idx_q <= idx_q + 1'b1;
          if (last_pos) begin
            st_q  <= ST_DOUBLE;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign status   = st_q;
  assign cand_cnt = cnt_q;
endmodule

// File: rtl/hsec_due_enum_chk.sv
module hsec_due_enum_chk
  import hsec_pkg::*;
#(
  parameter int MAX_CAND = 16,
  localparam int CNT_W   = $clog2(MAX_CAND + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             busy,
  input logic             done,
  input logic [1:0]       status,
  input logic [MSG_W-1:0] msg_out,
  input logic [CNT_W-1:0] cand_cnt
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cand_cnt <= CNT_W'(MAX_CAND));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !in_valid) |=> ($stable(status) && $stable(cand_cnt) && $stable(msg_out)));

  assert_double_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd2) |-> (cand_cnt != '0));

  assert_no_list_R1: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd2) |-> (cand_cnt == '0));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!busy && !done && cand_cnt == '0 && status == 2'd0));
endmodule

bind hsec_due_enum hsec_due_enum_chk #(.MAX_CAND(MAX_CAND)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .busy     (busy),
  .done     (done),
  .status   (status),
  .msg_out  (msg_out),
  .cand_cnt (cand_cnt)
);

// File: tb/hsec_due_enum_bench.sv
module hsec_due_enum_bench;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [38:0]   in_word = '0;
  logic          busy, done;
  logic [1:0]    status;
  logic [31:0]   msg_out;
  logic [4:0]    cand_cnt;
  logic [NC*32-1:0] cand_list;

  hsec_due_enum u_hsec_due_enum (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .busy(busy), .done(done), .status(status), .msg_out(msg_out),
    .cand_cnt(cand_cnt), .cand_list(cand_list)
  );

  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic [1:0]       st;
    logic [31:0]      msg;
    logic [4:0]       cnt;
    logic [NC*32-1:0] list;
    logic [31:0]      orig;
    logic             chk_orig;
    logic [31:0]      due_cyc;
  } exp_t;

  exp_t  exp_q[$];
  logic [6:0] hm [0:38];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NC*32-1:0] act, input logic [NC*32-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [6:0] bsyn(input logic [38:0] w);
    logic [6:0] s;
    s = '0;
    for (int p = 0; p < 39; p++) if (w[p]) s ^= hm[p];
    return s;
  endfunction

  function automatic logic [38:0] enc(input logic [31:0] m);
    return {bsyn({7'b0, m}), m};
  endfunction

  function automatic exp_t model(input logic [38:0] w);
    exp_t e;
    logic [6:0] s;
    e = '0;
    s = bsyn(w);
    e.msg = w[31:0];
    if (s == '0) begin
      e.st = 2'd0;
    end else if (^s) begin
      e.st = 2'd3;
      for (int p = 0; p < 39; p++) begin
        if (hm[p] == s) begin
          e.st = 2'd1;
          if (p < 32) e.msg = w[31:0] ^ (32'd1 << p);
        end
      end
    end else begin
      e.st = 2'd2;
      for (int i = 0; i < 39; i++) begin
        for (int j = i + 1; j < 39; j++) begin
          logic [38:0] c;
          c = w ^ (39'd1 << i) ^ (39'd1 << j);
          if (bsyn(c) == '0 && e.cnt < 5'(NC)) begin
            e.list[e.cnt*32 +: 32] = c[31:0];
            e.cnt = e.cnt + 1'b1;
          end
        end
      end
    end
    return e;
  endfunction

  // Driver: pushes the expected result, then offers the word.
  task automatic send(input logic [38:0] w, input logic [31:0] orig, input bit chk_orig);
    exp_t e;
    do @(negedge clk); while (busy);
    e = model(w);
    e.orig = orig;
    e.chk_orig = chk_orig;
    e.due_cyc = cyc + 1 + ((e.st == 2'd2) ? 40 : 1);
    exp_q.push_back(e);
    in_word = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string st_tag(input logic [1:0] st);
    case (st)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  // Monitor: pops and compares on every done pulse.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "done with no pending word", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = st_tag(e.st);
        check(status == e.st, t, "status", status, e.st);
        check(msg_out == e.msg, t, "msg_out", msg_out, e.msg);
        check(cand_cnt == e.cnt, t, "cand_cnt", cand_cnt, e.cnt);
        check(cyc == e.due_cyc, "R6", "done cycle", cyc, e.due_cyc);
        for (int k = 0; k < NC; k++) begin
          if (k < int'(e.cnt))
            check(cand_list[k*32 +: 32] == e.list[k*32 +: 32], "R3", "candidate slot",
                  cand_list[k*32 +: 32], e.list[k*32 +: 32]);
          else
            check(cand_list[k*32 +: 32] == 32'd0, "R8", "unused slot zero",
                  cand_list[k*32 +: 32], 0);
        end
        if (e.chk_orig) begin
          bit found;
          found = 0;
          for (int k = 0; k < NC; k++)
            if (k < int'(cand_cnt) && cand_list[k*32 +: 32] == e.orig) found = 1;
          check(found, "R4", "original message listed", cand_list, e.orig);
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(1'b0, "R6", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    begin : build_cols
      int n;
      n = 0;
      for (int v = 0; v < 128; v++) begin
        if ($countones(7'(v)) == 3 && n < 32) begin
          hm[n] = 7'(v);
          n++;
        end
      end
      for (int k = 0; k < 7; k++) hm[32 + k] = 7'(1 << k);
    end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(!busy && !done, "R9", "busy/done after reset", {busy, done}, 0);
    check(status == 2'd0, "R9", "status after reset", status, 0);
    check(cand_cnt == 5'd0, "R9", "cand_cnt after reset", cand_cnt, 0);
    check(msg_out == 32'd0, "R9", "msg_out after reset", msg_out, 0);
    check(cand_list == '0, "R9", "cand_list after reset", cand_list, 0);

    // R1: clean codewords
    send(enc(32'h0000_0000), 0, 0);
    send(enc(32'hFFFF_FFFF), 0, 0);
    send(enc(32'h1234_5678), 0, 0);
    send(enc(32'hA5A5_F00F), 0, 0);

    // R2: single flip at every position
    for (int p = 0; p < 39; p++)
      send(enc(32'hDEAD_BEEF) ^ (39'd1 << p), 0, 0);

    // R3/R4: fixed double flips covering data-data, check-check, data-check pairs
    begin : fixed_pairs
      int pi [6] = '{0, 32, 5, 31, 36, 3};
      int pj [6] = '{1, 33, 35, 38, 37, 20};
      logic [31:0] mm [3] = '{32'h0000_0000, 32'hC0FF_EE11, 32'h8000_0001};
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 3; b++)
          send(enc(mm[b]) ^ (39'd1 << pi[a]) ^ (39'd1 << pj[a]), mm[b], 1);
    end

    // R3/R4: pseudo-random double flips
    for (int r = 0; r < 30; r++) begin
      int i, j;
      logic [31:0] m;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      m = lfsr ^ 32'h5A5A_3C3C;
      i = int'(lfsr % 39);
      j = (i + 1 + int'((lfsr >> 8) % 38)) % 39;
      send(enc(m) ^ (39'd1 << i) ^ (39'd1 << j), m, 1);
    end

    // R5: triple flip whose odd syndrome matches no column
    begin : multi_case
      bit got;
      got = 0;
      for (int a = 0; a < 39 && !got; a++)
        for (int b = a + 1; b < 39 && !got; b++)
          for (int c = b + 1; c < 39 && !got; c++) begin
            logic [6:0] s;
            bit match;
            s = hm[a] ^ hm[b] ^ hm[c];
            match = 0;
            for (int p = 0; p < 39; p++) if (hm[p] == s) match = 1;
            if (^s && !match) begin
              got = 1;
              send(enc(32'h0F0F_0F0F) ^ (39'd1 << a) ^ (39'd1 << b) ^ (39'd1 << c), 0, 0);
            end
          end
      check(got, "R5", "unmatched odd syndrome found", got, 1);
    end

    // R7: word offered during a sweep is ignored
    send(enc(32'h2468_ACE0) ^ (39'd1 << 2) ^ (39'd1 << 9), 32'h2468_ACE0, 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R7", "busy during sweep", busy, 1);
    in_word = enc(32'h1111_1111);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;

    // drain
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);

    // R8: outputs hold with no accepted word
    begin : hold_case
      logic [1:0] s0;
      logic [31:0] m0;
      logic [4:0] c0;
      logic [NC*32-1:0] l0;
      s0 = status; m0 = msg_out; c0 = cand_cnt; l0 = cand_list;
      repeat (6) @(negedge clk);
      check(status == s0, "R8", "status held", status, s0);
      check(msg_out == m0, "R8", "msg_out held", msg_out, m0);
      check(cand_cnt == c0, "R8", "cand_cnt held", cand_cnt, c0);
      check(cand_list == l0, "R8", "cand_list held", cand_list, l0);
      check(!done && !busy, "R7", "no result from ignored word", {done, busy}, 0);
    end

    finish_run();
  end
endmodule